// File: doc/BRIEF.md
# Pipeline Interrupt and Transfer Injector

This block schedules the service of interrupt sources for a four-stage instruction pipeline (fetch, decode, execute, writeback). Instructions are abstract tokens that carry a tag and a few attribute bits. Each source has a request flag, an enable bit, a priority level and a mode bit. One prioritization round runs every cycle. A source in transfer mode is served by placing a transfer pseudo-instruction straight into the decode stage. A source in vectored mode is served by a one-cycle request pulse that carries its source number.

When a transfer is injected, the instruction that sat in fetch during the winning round is parked for one cycle and then re-enters decode. Program order around the pseudo-instruction is kept. A round is repeated when the instruction in decode reads a transfer-control register. After a return-from-interrupt token reaches execute, a guard window stops a new vectored service from starting until two instructions of the interrupted program have executed.

Top module: `pinj_core`

## Requirements
- R1: Synchronous active-high reset clears every request flag, the valid bit of every stage token, the parked slot, the guard counter and the in-service state. After reset `irq_vld` is 0 and `fet_take` is 1.
- R2: A pulse on `src_set[i]` sampled at a clock edge makes `pend[i]` read 1 in the next cycle.
- R3: The round winner is the pending, enabled source with the highest priority (`src_prio[i*PRIO_W +: PRIO_W]`, larger means more urgent). Ties go to the lowest index. A disabled source never wins, even while its flag stays set.
- R4: If a transfer-mode source's flag is set by the edge ending cycle 1, the transfer token is in decode in cycle 3 and that source's `pend` bit reads 0 in cycle 3. Token layout: bit TAG_W+3 valid, TAG_W+2 transfer, TAG_W+1 reads-control, TAG_W return, low TAG_W bits tag. A transfer token has tag = source index.
- R5: The instruction that was in fetch during the winning round reaches decode in cycle 4, one cycle after the transfer token. `fet_take` is 0 in cycle 3. Writeback then sees N, transfer, N+1, N+2 in that order.
- R6: If the token in decode during the round has its reads-control bit set and the winner is a transfer source, no injection happens that cycle. The transfer enters decode one cycle later than in R4.
- R7: At most one injection is outstanding. While a parked instruction waits, a transfer winner waits too, so back-to-back transfers reach decode two cycles apart.
- R8: A vectored-mode winner (mode bit 0) produces `irq_vld`=1 with `irq_id` set to its index in the next cycle, for one cycle. Its flag is cleared and nothing is injected.
- R9: After a vectored issue, no further vectored issue happens until a token with the return bit reaches execute.
- R10: After a return token is in execute in cycle t, vectored issue is held off until two program tokens have been in execute after it. Transfer pseudo-instructions and bubbles do not count. With no transfer, `irq_vld` rises no earlier than cycle t+4.
- R11: If a flag is set in the same cycle its source is cleared by winning, the set takes effect and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | NSRC | Request set pulses, one per source |
| src_en | input | NSRC | Source enable bits |
| src_xfer | input | NSRC | Mode: 1 transfer injection, 0 vectored |
| src_prio | input | NSRC*PRIO_W | Priority level per source |
| in_vld | input | 1 | Fetch token valid |
| in_rdc | input | 1 | Fetch token reads a transfer-control register |
| in_ret | input | 1 | Fetch token is a return-from-interrupt |
| in_tag | input | TAG_W | Fetch token tag |
| fet_take | output | 1 | Fetch token is accepted at the next edge |
| fch_tok | output | TAG_W+4 | Fetch stage token |
| dec_tok | output | TAG_W+4 | Decode stage token |
| exe_tok | output | TAG_W+4 | Execute stage token |
| wbk_tok | output | TAG_W+4 | Writeback stage token |
| pend | output | NSRC | Request flags |
| irq_vld | output | 1 | Vectored request pulse |
| irq_id | output | IDXW | Source number of the vectored request |

## Verification
The bench checks the stage contents cycle by cycle around an injection. A design that clears the flag late, injects a cycle early or drops the parked instruction shows a wrong tag in decode or writeback. The repeated round is driven with a control-register read in decode, which catches a design that ignores the attribute or delays by two cycles. Tied and disabled priorities are raised together so that a wrong tie rule or a leaking disabled source shows up. The guard window is measured with and without a transfer inside it; a design that counts the pseudo-instruction as program work issues the vectored request one cycle early.

// File: rtl/pinj_pkg.sv
package pinj_pkg;
  typedef enum logic [1:0] {ACT_IDLE, ACT_INJECT, ACT_VECTOR} act_e;
  // token bit offsets above the tag field
  localparam int OFS_RET = 0;
  localparam int OFS_RDC = 1;
  localparam int OFS_XFR = 2;
  localparam int OFS_VLD = 3;
  localparam int TOK_EXTRA = 4;
endpackage

// File: rtl/pinj_arbiter.sv
module pinj_arbiter #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int IDXW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   any,
  output logic [IDXW-1:0]        win
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best)) begin
        any  = 1'b1;
        win  = IDXW'(i);
        best = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_win_cand_R3: assert property (@(posedge clk) disable iff (rst)
    any |-> cand[win]);

  for (genvar g = 0; g < NSRC; g++) begin : g_prio_chk
    assert_win_prio_R3: assert property (@(posedge clk) disable iff (rst)
      (any && cand[g]) |-> (prio[g*PRIO_W +: PRIO_W] < prio[win*PRIO_W +: PRIO_W]
        || (prio[g*PRIO_W +: PRIO_W] == prio[win*PRIO_W +: PRIO_W] && win <= IDXW'(g))));
  end
endmodule

// File: rtl/pinj_guard.sv
module pinj_guard #(
  parameter int GUARD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vec_issue,
  input  logic ret_exe,
  input  logic prog_exe,
  output logic vec_ok
);
  localparam int CW = $clog2(GUARD + 1);
  logic          in_isr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_isr <= 1'b0;
      cnt    <= '0;
    end else begin
      if (vec_issue)    in_isr <= 1'b1;
      else if (ret_exe) in_isr <= 1'b0;
      if (ret_exe)                    cnt <= CW'(GUARD);
      else if (cnt != 0 && prog_exe)  cnt <= cnt - 1'b1;
    end
  end

  assign vec_ok = !in_isr && cnt == '0;

  assert_issue_block_R9: assert property (@(posedge clk) disable iff (rst)
    vec_issue |=> !vec_ok);
  assert_ret_guard_R10: assert property (@(posedge clk) disable iff (rst)
    ret_exe |=> !vec_ok);
  assert_guard_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt != 0 && !prog_exe && !ret_exe) |=> $stable(cnt));
endmodule

// File: rtl/pinj_pipe.sv
module pinj_pipe
  import pinj_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int TW    = TAG_W + TOK_EXTRA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    in_tok,
  input  logic             inject,
  input  logic [TAG_W-1:0] inj_tag,
  output logic [TW-1:0]    fch_tok,
  output logic [TW-1:0]    dec_tok,
  output logic [TW-1:0]    exe_tok,
  output logic [TW-1:0]    wbk_tok,
  output logic             park_vld,
  output logic             fet_take
);
  localparam int VB = TAG_W + OFS_VLD;
  localparam int XB = TAG_W + OFS_XFR;
  logic [TW-1:0] park_tok;
  logic [TW-1:0] xfr_tok;

  always_comb begin
    xfr_tok = '0;
    xfr_tok[VB] = 1'b1;
    xfr_tok[XB] = 1'b1;
    xfr_tok[TAG_W-1:0] = inj_tag;
  end

  assign fet_take = !park_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      fch_tok  <= '0;
      dec_tok  <= '0;
      exe_tok  <= '0;
      wbk_tok  <= '0;
      park_tok <= '0;
      park_vld <= 1'b0;
    end else begin
      wbk_tok <= exe_tok;
      exe_tok <= dec_tok;
      if (inject) begin
        dec_tok  <= xfr_tok;
        park_tok <= fch_tok;
        park_vld <= 1'b1;
        fch_tok  <= in_tok;
      end else if (park_vld) begin
        dec_tok  <= park_tok;
        park_vld <= 1'b0;
      end else begin
        dec_tok <= fch_tok;
        fch_tok <= in_tok;
      end
    end
  end

  assert_inject_dec_R4: assert property (@(posedge clk) disable iff (rst)
    inject |=> (dec_tok[VB] && dec_tok[XB] && dec_tok[TAG_W-1:0] == $past(inj_tag)));
  assert_one_out_R7: assert property (@(posedge clk) disable iff (rst)
    park_vld |-> !inject);
  assert_resume_R5: assert property (@(posedge clk) disable iff (rst)
    park_vld |=> dec_tok == $past(park_tok));
endmodule

// File: rtl/pinj_core.sv
module pinj_core
  import pinj_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int TAG_W  = 8,
  parameter int GUARD  = 2,
  parameter int IDXW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int TW     = TAG_W + TOK_EXTRA
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        src_set,
  input  logic [NSRC-1:0]        src_en,
  input  logic [NSRC-1:0]        src_xfer,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic                   in_vld,
  input  logic                   in_rdc,
  input  logic                   in_ret,
  input  logic [TAG_W-1:0]       in_tag,
  output logic                   fet_take,
  output logic [TW-1:0]          fch_tok,
  output logic [TW-1:0]          dec_tok,
  output logic [TW-1:0]          exe_tok,
  output logic [TW-1:0]          wbk_tok,
  output logic [NSRC-1:0]        pend,
  output logic                   irq_vld,
  output logic [IDXW-1:0]        irq_id
);
  localparam int VB = TAG_W + OFS_VLD;
  localparam int XB = TAG_W + OFS_XFR;
  localparam int CB = TAG_W + OFS_RDC;
  localparam int RB = TAG_W + OFS_RET;

  logic            any;
  logic [IDXW-1:0] win;
  logic            park_vld;
  logic            vec_ok;
  logic            dec_rdc;
  logic            ret_exe;
  logic            prog_exe;
  logic [NSRC-1:0] clr;
  logic [TW-1:0]   in_tok;
  act_e            act;

  assign in_tok   = {in_vld, 1'b0, in_rdc, in_ret, in_tag};
  assign dec_rdc  = dec_tok[VB] && dec_tok[CB] && !dec_tok[XB];
  assign prog_exe = exe_tok[VB] && !exe_tok[XB];
  assign ret_exe  = prog_exe && exe_tok[RB];

  pinj_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDXW(IDXW)) arb_i (
    .clk(clk), .rst(rst), .cand(pend & src_en), .prio(src_prio),
    .any(any), .win(win));

  always_comb begin
    act = ACT_IDLE;
    if (any) begin
      if (src_xfer[win]) begin
        if (!park_vld && !dec_rdc) act = ACT_INJECT;
      end else if (vec_ok) begin
        act = ACT_VECTOR;
      end
    end
    clr = '0;
    if (act != ACT_IDLE) clr[win] = 1'b1;
  end

  pinj_pipe #(.TAG_W(TAG_W), .TW(TW)) pipe_i (
    .clk(clk), .rst(rst), .in_tok(in_tok),
    .inject(act == ACT_INJECT), .inj_tag(TAG_W'(win)),
    .fch_tok(fch_tok), .dec_tok(dec_tok), .exe_tok(exe_tok), .wbk_tok(wbk_tok),
    .park_vld(park_vld), .fet_take(fet_take));

  pinj_guard #(.GUARD(GUARD)) guard_i (
    .clk(clk), .rst(rst), .vec_issue(act == ACT_VECTOR),
    .ret_exe(ret_exe), .prog_exe(prog_exe), .vec_ok(vec_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      irq_vld <= 1'b0;
      irq_id  <= '0;
    end else begin
      pend    <= (pend & ~clr) | src_set;
      irq_vld <= (act == ACT_VECTOR);
      if (act == ACT_VECTOR) irq_id <= win;
    end
  end

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_INJECT) |=> pend[$past(win)] == $past(src_set[win]));
  assert_repeat_R6: assert property (@(posedge clk) disable iff (rst)
    dec_rdc |-> act != ACT_INJECT);
  assert_vec_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_VECTOR) |=> (irq_vld && irq_id == $past(win) && !dec_tok[XB]));
  assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_IDLE) |-> src_en[win]);
endmodule

// File: tb/pinj_core_tb_top.sv
module pinj_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int PRIO_W = 3;
  localparam int TAG_W = 8;
  localparam int IDXW = 3;
  localparam int TW = TAG_W + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_set = '0;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] src_xfer;
  logic [NSRC*PRIO_W-1:0] src_prio;
  logic in_vld = 1'b0, in_rdc = 1'b0, in_ret = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic fet_take;
  logic [TW-1:0] fch_tok, dec_tok, exe_tok, wbk_tok;
  logic [NSRC-1:0] pend;
  logic irq_vld;
  logic [IDXW-1:0] irq_id;

  int checks = 0, fails = 0;
  int pc = 0, rdc_pc = -1, ret_pc = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinj_core #(.NSRC(NSRC), .PRIO_W(PRIO_W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .src_set(src_set), .src_en(src_en), .src_xfer(src_xfer),
    .src_prio(src_prio), .in_vld(in_vld), .in_rdc(in_rdc), .in_ret(in_ret),
    .in_tag(in_tag), .fet_take(fet_take), .fch_tok(fch_tok), .dec_tok(dec_tok),
    .exe_tok(exe_tok), .wbk_tok(wbk_tok), .pend(pend), .irq_vld(irq_vld), .irq_id(irq_id));

  function automatic int tg(input logic [TW-1:0] t); return int'(t[TAG_W-1:0]); endfunction
  function automatic int tv(input logic [TW-1:0] t); return int'(t[TW-1]); endfunction
  function automatic int tx(input logic [TW-1:0] t); return int'(t[TW-2]); endfunction
  function automatic int tr(input logic [TW-1:0] t); return int'(t[TAG_W]); endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive the program token, advance pc if it was taken
  task automatic step();
    bit tk;
    in_vld = 1'b1;
    in_tag = pc[TAG_W-1:0];
    in_rdc = (pc == rdc_pc);
    in_ret = (pc == ret_pc);
    tk = fet_take;
    @(posedge clk);
    if (tk) pc++;
    @(negedge clk);
    src_set = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    chk("R1 pend", int'(pend), 0);
    chk("R1 dec valid", tv(dec_tok), 0);
    chk("R1 wbk valid", tv(wbk_tok), 0);
    chk("R1 irq_vld", int'(irq_vld), 0);
    chk("R1 fet_take", int'(fet_take), 1);
    rst = 1'b0;
    idle(5);
  endtask

  task automatic t_inject();
    int n;
    src_set[3] = 1'b1;
    step();                                   // cycle 2
    chk("R2 pend set", int'(pend[3]), 1);
    n = tg(dec_tok);
    step();                                   // cycle 3
    chk("R4 dec xfer", tx(dec_tok), 1);
    chk("R4 dec tag", tg(dec_tok), 3);
    chk("R4 flag cleared", int'(pend[3]), 0);
    chk("R5 exe is N", tg(exe_tok), n);
    chk("R5 fetch held off", int'(fet_take), 0);
    chk("R5 fetch N+2", tg(fch_tok), (n + 2) & 255);
    step();                                   // cycle 4
    chk("R5 dec N+1", tg(dec_tok), (n + 1) & 255);
    chk("R5 dec N+1 not xfer", tx(dec_tok), 0);
    chk("R5 exe xfer", tx(exe_tok), 1);
    step();                                   // cycle 5
    chk("R5 wbk xfer", tx(wbk_tok), 1);
    chk("R5 exe N+1", tg(exe_tok), (n + 1) & 255);
    chk("R5 dec N+2", tg(dec_tok), (n + 2) & 255);
    idle(3);
  endtask

  task automatic t_repeat();
    int n;
    rdc_pc = pc;
    step();                                   // cycle 1: reader in fetch
    rdc_pc = -1;
    src_set[3] = 1'b1;
    step();                                   // cycle 2: reader in decode
    n = tg(dec_tok);
    step();                                   // cycle 3: round repeated
    chk("R6 no inject yet", tx(dec_tok), 0);
    chk("R6 dec N+1", tg(dec_tok), (n + 1) & 255);
    chk("R6 flag still set", int'(pend[3]), 1);
    step();                                   // cycle 4
    chk("R6 late inject", tx(dec_tok), 1);
    chk("R6 late tag", tg(dec_tok), 3);
    chk("R6 flag cleared", int'(pend[3]), 0);
    idle(3);
  endtask

  task automatic t_arb();
    src_set[1] = 1'b1; src_set[5] = 1'b1; src_set[6] = 1'b1; src_set[2] = 1'b1;
    step();                                   // cycle 2
    step();                                   // cycle 3
    chk("R3 tie lowest index", tg(dec_tok), 5);
    chk("R3 tie loser pending", int'(pend[6]), 1);
    step();                                   // cycle 4
    chk("R7 wait while parked", tx(dec_tok), 0);
    step();                                   // cycle 5
    chk("R7 second xfer", tg(dec_tok) + 16 * tx(dec_tok), 16 + 6);
    step();
    step();                                   // cycle 7
    chk("R3 lower priority last", tg(dec_tok) + 16 * tx(dec_tok), 16 + 1);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R3 disabled never injected", (tx(dec_tok) == 1 && tg(dec_tok) == 2) ? 1 : 0, 0);
    end
    chk("R3 disabled stays pending", int'(pend[2]), 1);
  endtask

  task automatic t_setclr();
    src_set[5] = 1'b1;
    step();                                   // cycle 2
    src_set[5] = 1'b1;
    step();                                   // cycle 3
    chk("R11 xfer injected", tg(dec_tok) + 16 * tx(dec_tok), 16 + 5);
    chk("R11 set beats clear", int'(pend[5]), 1);
    step();                                   // cycle 4
    step();                                   // cycle 5
    chk("R11 second xfer", tg(dec_tok) + 16 * tx(dec_tok), 16 + 5);
    chk("R11 flag cleared", int'(pend[5]), 0);
    idle(3);
  endtask

  task automatic t_vector();
    src_set[4] = 1'b1;
    step();
    chk("R8 pending", int'(pend[4]), 1);
    step();
    chk("R8 irq pulse", int'(irq_vld), 1);
    chk("R8 irq id", int'(irq_id), 4);
    chk("R8 flag cleared", int'(pend[4]), 0);
    chk("R8 no injection", tx(dec_tok), 0);
    step();
    chk("R8 one cycle pulse", int'(irq_vld), 0);
    src_set[4] = 1'b1;
    step();
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 blocked in service", int'(irq_vld), 0);
    end
    chk("R9 still pending", int'(pend[4]), 1);
    ret_pc = pc;
    step();                                   // return in fetch
    ret_pc = -1;
    chk("R9 return fetched", tr(fch_tok), 1);
    step();
    step();                                   // cycle t
    chk("R10 return in execute", tr(exe_tok), 1);
    for (int i = 1; i <= 3; i++) begin
      step();
      chk("R10 guard holds", int'(irq_vld), 0);
    end
    step();                                   // cycle t+4
    chk("R10 issue after guard", int'(irq_vld), 1);
    chk("R10 issue id", int'(irq_id), 4);
    idle(2);
  endtask

  task automatic t_guard_xfer();
    src_set[4] = 1'b1;
    idle(3);
    ret_pc = pc;
    step();                                   // cycle a
    ret_pc = -1;
    src_set[7] = 1'b1;
    step();                                   // cycle a+1
    chk("R10 return in decode", tr(dec_tok), 1);
    step();                                   // cycle t
    chk("R10 return executes", tr(exe_tok), 1);
    chk("R10 xfer behind return", tg(dec_tok) + 16 * tx(dec_tok), 16 + 7);
    step();                                   // t+1
    chk("R10 xfer in execute", tx(exe_tok), 1);
    for (int i = 2; i <= 4; i++) begin
      step();
      chk("R10 xfer not counted", int'(irq_vld), 0);
    end
    step();                                   // t+5
    chk("R10 delayed issue", int'(irq_vld), 1);
  endtask

  initial begin
    src_en = 8'b1111_1011;
    src_xfer = 8'b1110_1111;
    src_prio = {3'd6, 3'd5, 3'd5, 3'd3, 3'd4, 3'd7, 3'd2, 3'd1};
    @(negedge clk);
    t_reset();
    t_inject();
    t_repeat();
    t_arb();
    t_setclr();
    t_vector();
    t_guard_xfer();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule